// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write byte-wide registers on a chip's internal parallel bus. The master pulls chip select low and sends a 16-bit control word. The word holds a direction bit, a 14-bit register address and a burst flag. One or more data bytes follow. A write produces a one-cycle write strobe on the register bus with the address and the data byte. A read produces a one-cycle read strobe and then shifts the returned byte out on SDO.

Clock polarity, clock phase and bit order are static configuration inputs, and all four SPI modes are supported. The block runs entirely in the system clock domain. Chip select, SCLK and SDI pass through two-flop synchronizers, and the synchronized SCLK is edge-detected. The system clock must therefore run at least 8 times faster than SCLK.

Top module: `spi_reg_port`

## Requirements
- R1: While chip select is high, and after reset, the SDO output-enable is low and neither register strobe is pulsed.
- R2: With bit order set to MSB-first, the control word arrives as direction (1 = read, 0 = write), address bits 13 down to 0, then the burst flag (1 = burst). Data bytes travel most significant bit first.
- R3: With bit order set to LSB-first, the control word arrives as direction, address bits 0 up to 13, then the burst flag. Every data byte travels least significant bit first, on both SDI and SDO.
- R4: All four modes work. CPOL=0 means SCLK idles low and CPOL=1 means it idles high. With CPHA=0, SDI is sampled on the leading edge and SDO changes on the trailing edge. With CPHA=1, SDI is sampled on the trailing edge and SDO changes on the next leading edge.
- R5: A single write (burst flag 0) issues exactly one write strobe, carrying the control-word address and the first data byte. Later bytes have no effect.
- R6: A burst write issues one write strobe per complete byte. The address starts at the control-word address and increases by one after each strobe.
- R7: A single read issues one read strobe at the control-word address and drives that byte on SDO with the output-enable high. SDO is released (output-enable low) for any byte clocked after it. The output-enable stays low throughout the control word.
- R8: A burst read returns bytes from consecutive addresses. Each byte is fetched with a read strobe as soon as the previous byte has been received in full, so one fetch is made beyond the last byte the master clocks out.
- R9: When chip select rises partway through a data byte, that partial byte is discarded and no write strobe is issued for it.
- R10: The register address is 14 bits wide. In a burst it wraps from 3FFF (hex) to 0.
- R11: Each write or read strobe lasts exactly one system clock, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first_i | input | 1 | 1: LSB-first bit order, 0: MSB-first |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| sdo_oe_o | output | 1 | Output-enable for the SDO pad driver |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | DATA_W | Read data, valid in the cycle reg_re_o is high |

## Verification
The bench instantiates the port with its default parameters: a 14-bit address, 8-bit data and two synchronizer stages. SCLK runs at one sixteenth of the system clock. The 14-bit address makes the 3FFF-to-0 wrap reachable in a three-byte burst. The 8-bit data width keeps every transaction short, so each of the four modes can be crossed with both bit orders and both directions. The register model behind the bus is a pure function of the address, so every read byte is known in advance.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned DEF_ADDR_W  = 14;
  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic cs_act_i,
  input  logic sclk_s_i,
  output logic sample_o,
  output logic shift_o
);
  logic prev_q;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sclk_s_i;
  end

  assign rise  = sclk_s_i & ~prev_q;
  assign fall  = ~sclk_s_i & prev_q;
  // leading edge leaves the idle level
  assign lead  = cpol_i ? fall : rise;
  assign trail = cpol_i ? rise : fall;

  assign sample_o = cs_act_i & (cpha_i ? trail : lead);
  assign shift_o  = cs_act_i & (cpha_i ? lead : trail);

  // R4
  sample_shift_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && shift_o));
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic              lsb_first_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  localparam int unsigned CW_W  = ADDR_W + 2;
  localparam int unsigned CNT_W = $clog2(CW_W + 1);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CW_W - 1);
  localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(DATA_W - 1);

  logic [CW_W-1:0]   sh_q, nxt_sh;
  logic [CNT_W-1:0]  cnt_q;
  logic              cw_done_q, rw_q, burst_q, first_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, re_q;
  logic              ctrl_last, byte_last;

  function automatic logic [ADDR_W-1:0] rev_a(input logic [ADDR_W-1:0] v);
    for (int i = 0; i < int'(ADDR_W); i++) rev_a[i] = v[ADDR_W-1-i];
  endfunction

  function automatic logic [DATA_W-1:0] rev_d(input logic [DATA_W-1:0] v);
    for (int i = 0; i < int'(DATA_W); i++) rev_d[i] = v[DATA_W-1-i];
  endfunction

  // one left shifter for both orders; LSB-first fields are mirrored on use
  assign nxt_sh    = {sh_q[CW_W-2:0], sdi_i};
  assign ctrl_last = !cw_done_q && (cnt_q == CTRL_LAST);
  assign byte_last = cw_done_q && (cnt_q[BIT_W-1:0] == BYTE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      cw_done_q <= 1'b0;
      rw_q      <= 1'b0;
      burst_q   <= 1'b0;
      first_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if ((we_q || re_q) && burst_q) addr_q <= addr_q + 1'b1;
      if (!cs_act_i) begin
        cnt_q     <= '0;
        cw_done_q <= 1'b0;
        first_q   <= 1'b0;
      end else if (sample_i) begin
        sh_q <= nxt_sh;
        if (ctrl_last) begin
          cnt_q     <= '0;
          cw_done_q <= 1'b1;
          first_q   <= 1'b1;
          rw_q      <= nxt_sh[CW_W-1];
          burst_q   <= nxt_sh[0];
          addr_q    <= lsb_first_i ? rev_a(nxt_sh[CW_W-2:1]) : nxt_sh[CW_W-2:1];
          re_q      <= nxt_sh[CW_W-1];
        end else if (byte_last) begin
          cnt_q   <= '0;
          first_q <= 1'b0;
          if (!rw_q && (burst_q || first_q)) begin
            we_q    <= 1'b1;
            wdata_q <= lsb_first_i ? rev_d(nxt_sh[DATA_W-1:0]) : nxt_sh[DATA_W-1:0];
          end
          // prefetch the next burst byte before its first bit is due
          if (rw_q && burst_q) re_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && re_q));
  // R11
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  // R6
  burst_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q || re_q) && burst_q |=> addr_q == $past(addr_q) + 1'b1);
  // R5
  single_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q || re_q) && !burst_q |=> $stable(addr_q));
  // R9
  we_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_q) |-> $past(sample_i && cs_act_i));
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              shift_i,
  input  logic              lsb_first_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] byte_q;
  logic [BIT_W-1:0]  idx_q, sel;
  logic              valid_q, sdo_q, oe_q;

  assign sel = lsb_first_i ? idx_q : (BYTE_LAST - idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!cs_act_i) begin
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (load_i) begin
      byte_q  <= load_data_i;
      valid_q <= 1'b1;
      idx_q   <= '0;
    end else if (shift_i) begin
      if (valid_q) begin
        sdo_q <= byte_q[sel];
        oe_q  <= 1'b1;
        idx_q <= idx_q + 1'b1;
        if (idx_q == BYTE_LAST) valid_q <= 1'b0;
      end else begin
        oe_q <= 1'b0;
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;

  // R1
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !oe_q);
  // R4
  sdo_on_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && cs_act_i) |=> $stable(sdo_q));
  // R7
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(shift_i));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [2:0] pins_s;
  logic       cs_act, sample, shift;

  // cs, sclk, sdi share one synchronizer so their skew is preserved
  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .cs_act_i(cs_act),
    .sclk_s_i(pins_s[1]),
    .sample_o(sample),
    .shift_o (shift)
  );

  spi_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sample_i   (sample),
    .sdi_i      (pins_s[0]),
    .lsb_first_i(lsb_first_i),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o)
  );

  spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .shift_i    (shift),
    .lsb_first_i(lsb_first_i),
    .load_i     (reg_re_o),
    .load_data_i(reg_rdata_i),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );
endmodule

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, we, re;
  logic [13:0] addr;
  logic [7:0]  wdata, rdata;

  function automatic logic [7:0] model(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
  endfunction

  assign rdata = model(addr);

  spi_reg_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb),
    .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re),
    .reg_rdata_i(rdata)
  );

  // bus log
  logic log_clr = 1'b0;
  int wr_n, rd_n, both_n;
  logic [13:0] wr_a [8];
  logic [7:0]  wr_d [8];
  logic [13:0] rd_a [8];
  always @(posedge clk) begin
    if (log_clr) begin
      wr_n <= 0; rd_n <= 0; both_n <= 0;
    end else begin
      if (we) begin
        if (wr_n < 8) begin wr_a[wr_n] <= addr; wr_d[wr_n] <= wdata; end
        wr_n <= wr_n + 1;
      end
      if (re) begin
        if (rd_n < 8) rd_a[rd_n] <= addr;
        rd_n <= rd_n + 1;
      end
      if (we && re) both_n <= both_n + 1;
    end
  end

  int n_cmp = 0, n_err = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // master
  logic r_bit, r_oe, oe_ctrl;
  logic [7:0] tx_d [4];
  logic [7:0] rx_d [4];
  logic oe_all [4];
  logic oe_any [4];

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_io(input logic b);
    if (!cpha) begin
      sdi = b; half();
      r_bit = sdo; r_oe = sdo_oe;
      sclk = ~cpol; half(); sclk = cpol;
    end else begin
      sclk = ~cpol; sdi = b; half();
      r_bit = sdo; r_oe = sdo_oe;
      sclk = cpol; half();
    end
  endtask

  task automatic txn(input logic rw, input logic burst, input logic [13:0] a,
                     input int nb, input int cut);
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
    sclk = cpol;
    repeat (6) @(negedge clk);
    cs_n = 1'b0; oe_ctrl = 1'b0;
    half();
    bit_io(rw); oe_ctrl |= r_oe;
    for (int i = 0; i < 14; i++) begin
      bit_io(lsb ? a[i] : a[13-i]); oe_ctrl |= r_oe;
    end
    bit_io(burst); oe_ctrl |= r_oe;
    for (int k = 0; k < nb; k++) begin
      oe_all[k] = 1'b1; oe_any[k] = 1'b0;
      for (int i = 0; i < 8; i++) begin
        bit_io(lsb ? tx_d[k][i] : tx_d[k][7-i]);
        rx_d[k][lsb ? i : 7-i] = r_bit;
        oe_all[k] &= r_oe; oe_any[k] |= r_oe;
      end
    end
    for (int i = 0; i < cut; i++) bit_io(1'b1);
    half();
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // cpol, cpha, lsb, rw, addr, data
  localparam logic [25:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 14'h1234, 8'h5C},
    {1'b0, 1'b0, 1'b1, 1'b1, 14'h0ABC, 8'h00},
    {1'b0, 1'b1, 1'b0, 1'b1, 14'h3FFE, 8'h00},
    {1'b0, 1'b1, 1'b1, 1'b0, 14'h2001, 8'h81},
    {1'b1, 1'b0, 1'b0, 1'b1, 14'h0007, 8'h00},
    {1'b1, 1'b0, 1'b1, 1'b0, 14'h1F0F, 8'h3E},
    {1'b1, 1'b1, 1'b0, 1'b0, 14'h0100, 8'hC3},
    {1'b1, 1'b1, 1'b1, 1'b1, 14'h2AAA, 8'h00}
  };

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 oe after reset", sdo_oe, 0);
    chk("R1 we after reset", we, 0);
    chk("R1 re after reset", re, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [13:0] va;
      logic [7:0]  vd;
      logic        vrw;
      {cpol, cpha, lsb, vrw, va, vd} = VECS[v];
      tx_d[0] = vd; tx_d[1] = ~vd;
      txn(vrw, 1'b0, va, 2, 0);
      chk("R4 R11 strobes never together", both_n, 0);
      chk("R7 oe low in control word", oe_ctrl, 0);
      if (!vrw) begin
        // R2 R3 R4 R5 single write, second byte ignored
        chk(lsb ? "R3 R5 write count" : "R2 R5 write count", wr_n, 1);
        chk(lsb ? "R3 write addr" : "R2 write addr", wr_a[0], va);
        chk(lsb ? "R3 write data" : "R2 write data", wr_d[0], vd);
        chk("R5 no read on write", rd_n, 0);
        chk("R1 oe low on write", oe_any[0] | oe_any[1], 0);
      end else begin
        chk(lsb ? "R3 R7 read count" : "R2 R7 read count", rd_n, 1);
        chk("R7 read addr", rd_a[0], va);
        chk(lsb ? "R3 R4 read byte" : "R2 R4 read byte", rx_d[0], model(va));
        chk("R7 oe during byte", oe_all[0], 1);
        chk("R7 oe released after byte", oe_any[1], 0);
        chk("R7 no write on read", wr_n, 0);
      end
      chk("R1 oe low after cs high", sdo_oe, 0);
    end

    // R6 R10 burst write across address wrap, mode 0 MSB-first
    cpol = 0; cpha = 0; lsb = 0;
    tx_d[0] = 8'h11; tx_d[1] = 8'h22; tx_d[2] = 8'h33;
    txn(1'b0, 1'b1, 14'h3FFE, 3, 0);
    chk("R6 burst write count", wr_n, 3);
    chk("R6 burst addr 0", wr_a[0], 14'h3FFE);
    chk("R6 burst addr 1", wr_a[1], 14'h3FFF);
    chk("R10 burst wrap addr", wr_a[2], 14'h0000);
    chk("R6 burst data 2", wr_d[2], 8'h33);

    // R8 burst read, mode 3 LSB-first
    cpol = 1; cpha = 1; lsb = 1;
    tx_d[0] = 0; tx_d[1] = 0; tx_d[2] = 0;
    txn(1'b1, 1'b1, 14'h0010, 3, 0);
    chk("R8 burst read fetch count", rd_n, 4);
    chk("R8 burst read addr 2", rd_a[2], 14'h0012);
    chk("R8 burst byte 0", rx_d[0], model(14'h0010));
    chk("R8 burst byte 1", rx_d[1], model(14'h0011));
    chk("R8 burst byte 2", rx_d[2], model(14'h0012));
    chk("R8 oe held in burst", oe_all[2], 1);

    // R9 partial bytes
    cpol = 0; cpha = 1; lsb = 0;
    txn(1'b0, 1'b0, 14'h0055, 0, 5);
    chk("R9 partial single write dropped", wr_n, 0);
    tx_d[0] = 8'h9A;
    txn(1'b0, 1'b1, 14'h0200, 1, 3);
    chk("R9 burst partial tail dropped", wr_n, 1);
    chk("R9 complete byte kept", wr_d[0], 8'h9A);
    chk("R1 oe after abort", sdo_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule